// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Serial Controller

This block is the serial control core of a two-channel digital potentiometer. A host talks to it over a four-wire SPI link framed by an active-low chip select. Each transaction opens with an identification byte that carries a fixed device-type nibble and a two-bit board address. An instruction byte follows, and for some commands a single data byte after that. For each channel the block holds a live 6-bit wiper register and a bank of four stored data registers. It decodes each wiper register into a one-hot selection over 64 switch lines.

Writes to the stored data registers go to a modelled nonvolatile bank. They are committed only after chip select is released at the end of a complete command. The save then keeps a busy flag set for a fixed number of clock cycles. The host polls that flag with a status command, and write commands are refused while it is set. The data registers keep their contents through the synchronous reset, and the reset loads each wiper from its channel's register 0.

The SPI pins are oversampled by the system clock, which must run at least 16 times faster than the serial clock.

Top module: `digipot_spi_ctrl`

## Requirements
- R1: Each of the two channels has its own 6-bit wiper register. Opcode 1010 loads that register from bits 5:0 of the data byte that follows the instruction. The wiper outputs change only inside a transaction, or during reset.
- R2: For channel c, wiper_sel bit c*64+k is high exactly when the channel's wiper holds k. Exactly one of the channel's 64 lines is high at all times.
- R3: Opcode 1101 copies data register `reg` of the addressed channel into that channel's wiper, with no data byte needed.
- R4: Opcode 1001 returns the wiper of the addressed channel and opcode 1011 returns the addressed data register. The value is zero-padded to 8 bits and shifted out MSB first on spi_miso during the byte after the instruction.
- R5: Bits 7:4 of the identification byte must be 0101 and bits 1:0 must equal addr_strap; bits 3:2 are don't-care. On any mismatch the rest of the transaction is ignored.
- R6: Opcode 1100 (data byte bits 5:0 into register `reg`) and opcode 1110 (wiper into register `reg`) are committed only when chip select rises after the command is complete. The data register takes the new value when the save ends. A command cut short before its last bit saves nothing.
- R7: A save holds nv_busy high for NV_CYCLES clock cycles. Opcode 0101 returns nv_busy in bit 0 of the byte after the instruction, with bits 7:1 zero.
- R8: While nv_busy is high, opcodes 1010, 1100, 1101 and 1110 are ignored. Reads and the status command are still served.
- R9: With wp_n low when the command is received, opcodes 1100 and 1110 are ignored and no save starts.
- R10: Reset loads each wiper from that channel's data register 0. The data registers keep their values through reset, and their power-up value is zero.
- R11: While hold_n is low, SCK edges are ignored and spi_miso_oe is low. The transaction resumes intact when hold_n goes high again.
- R12: SPI mode 0 is used. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. spi_miso_oe is high only while chip select is low and hold_n is high.
- R13: The instruction byte is laid out as [7:4] opcode, [3:2] register index, [1:0] channel. A channel value of 2 or 3 makes the command ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| wp_n | input | 1 | Active-low write protect for the data registers |
| addr_strap | input | 2 | Board address compared with the identification byte |
| wiper_sel | output | N_CH*64 (128) | One-hot switch selects, 64 lines per channel |
| nv_busy | output | 1 | Nonvolatile save in progress |

## Verification
Every SPI pin passes through a two-flop synchroniser and an edge detector. As a result, a wiper update is visible on wiper_sel four clocks after the SCK edge that completes the byte. MISO carries a new bit three clocks after the falling SCK edge, and nv_busy rises two clocks after chip select is seen high. The bench uses an SCK half period of eight clocks. It samples MISO one clock before each rising SCK edge, and it checks wiper_sel and nv_busy only after waiting four half periods past the chip-select rise, so every result has settled. Saves are checked twice: at the first status poll after chip select rises, and again after a poll loop confirms nv_busy has fallen.

// File: rtl/digipot_pkg.sv
// Shared constants and types for the digital potentiometer serial controller.
// Assumes a byte-oriented SPI protocol: identification, instruction, data.
package digipot_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [3:0] {
        OP_STATUS = 4'b0101,
        OP_RD_WCR = 4'b1001,
        OP_WR_WCR = 4'b1010,
        OP_RD_DR  = 4'b1011,
        OP_WR_DR  = 4'b1100,
        OP_DR2WCR = 4'b1101,
        OP_WCR2DR = 4'b1110
    } op_e;

    typedef enum logic [1:0] {
        PH_ID,
        PH_INSN,
        PH_DATA,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/digipot_spi_front.sv
// SPI mode-0 front end: synchronises the pins into clk, finds SCK edges,
// assembles received bytes MSB first and shifts a loaded byte out on MISO.
// Assumes clk runs well above SCK so every SCK level lasts several clocks.
module digipot_spi_front (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       hold_n,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       cs_act,
    output logic       cs_rise,
    output logic       byte_stb,
    output logic [7:0] rx_byte,
    output logic       so_bit,
    output logic       so_oe
);

    logic [2:0] sck_s;
    logic [2:0] cs_s;
    logic [1:0] si_s;
    logic [1:0] hold_s;
    logic [6:0] rx_sh;
    logic [2:0] bit_cnt;
    logic [7:0] tx_sh;
    logic       hold_act;
    logic       sck_rise;
    logic       sck_fall;

    // Bring the asynchronous pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= '0;
            cs_s   <= '1;
            si_s   <= '0;
            hold_s <= '1;
        end else begin
            sck_s  <= {sck_s[1:0], spi_sck};
            cs_s   <= {cs_s[1:0], spi_cs_n};
            si_s   <= {si_s[0], spi_mosi};
            hold_s <= {hold_s[0], hold_n};
        end
    end

    assign cs_act   = ~cs_s[1];
    assign cs_rise  = cs_s[1] & ~cs_s[2];
    assign hold_act = ~hold_s[1];
    assign sck_rise = sck_s[1] & ~sck_s[2] & cs_act & ~hold_act;
    assign sck_fall = ~sck_s[1] & sck_s[2] & cs_act & ~hold_act;

    // Receive shifter: one byte strobe for every eight rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            bit_cnt  <= '0;
            byte_stb <= 1'b0;
            rx_byte  <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (!cs_act) begin
                rx_sh   <= '0;
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], si_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    rx_byte  <= {rx_sh, si_s[1]};
                end
            end
        end
    end

    // Transmit shifter: a new MISO bit after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            so_bit <= 1'b0;
        end else if (!cs_act) begin
            tx_sh  <= '0;
            so_bit <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (sck_fall) begin
            so_bit <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
        end
    end

    // MISO pad enable: selected and not paused.
    always_ff @(posedge clk) begin
        if (!rst_n) so_oe <= 1'b0;
        else        so_oe <= cs_act & ~hold_act;
    end

endmodule

// File: rtl/digipot_nv_timer.sv
// Models the nonvolatile programming time: once started, stays busy for
// exactly NV_CYCLES clocks and pulses done in the last busy cycle.
// Assumes start is ignored while busy.
module digipot_nv_timer #(
    parameter int NV_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(NV_CYCLES + 1);

    logic [CNT_W-1:0] remain_q;

    // Count down the programming window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            remain_q <= CNT_W'(NV_CYCLES - 1);
        end else if (busy) begin
            if (remain_q == '0) busy <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
        end
    end

    assign done = busy && (remain_q == '0);

endmodule

// File: rtl/digipot_cmd.sv
// Protocol engine: checks the identification byte, decodes the instruction,
// holds the wiper registers and the retained data-register bank, and arms a
// deferred data-register commit that starts when chip select rises.
// Assumes N_CH <= 4, N_DR <= 4 and WCR_W < 8.
module digipot_cmd
    import digipot_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int WCR_W = 6,
    parameter int N_DR  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               cs_rise,
    input  logic               byte_stb,
    input  logic [7:0]         rx_byte,
    input  logic [1:0]         addr_strap,
    input  logic               wp_n,
    input  logic               nv_busy,
    input  logic               nv_done,
    output logic               tx_load,
    output logic [7:0]         tx_byte,
    output logic               nv_start,
    output logic [N_CH*WCR_W-1:0] wcr_flat
);

    localparam int CHI_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int DRI_W = (N_DR > 1) ? $clog2(N_DR) : 1;
    localparam int PAD_W = 8 - WCR_W;

    phase_e           phase_q;
    op_e              op_q;
    logic [CHI_W-1:0] ch_q;
    logic [WCR_W-1:0] wcr_q [N_CH];
    logic [WCR_W-1:0] dr_q  [N_CH][N_DR] = '{default: '0};
    logic             pend_armed_q;
    logic [CHI_W-1:0] pend_ch_q;
    logic [DRI_W-1:0] pend_reg_q;
    logic [WCR_W-1:0] pend_val_q;
    logic [DRI_W-1:0] reg_q;

    logic             id_ok;
    op_e              ins_op;
    logic [CHI_W-1:0] ch_i;
    logic [DRI_W-1:0] reg_i;
    logic             ch_ok;
    logic             reg_ok;

    // Field extraction from the received byte.
    assign id_ok  = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[1:0] == addr_strap);
    assign ins_op = op_e'(rx_byte[7:4]);
    assign ch_i   = rx_byte[CHI_W-1:0];
    assign reg_i  = rx_byte[DRI_W+1:2];
    assign ch_ok  = int'(rx_byte[1:0]) < N_CH;
    assign reg_ok = int'(rx_byte[3:2]) < N_DR;

    assign nv_start = cs_rise & pend_armed_q & ~nv_busy;

    // Transaction sequencing, wiper updates and commit arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) wcr_q[c] <= dr_q[c][0];
            phase_q      <= PH_ID;
            op_q         <= OP_STATUS;
            ch_q         <= '0;
            reg_q        <= '0;
            tx_load      <= 1'b0;
            tx_byte      <= '0;
            pend_armed_q <= 1'b0;
            pend_ch_q    <= '0;
            pend_reg_q   <= '0;
            pend_val_q   <= '0;
        end else begin
            tx_load <= 1'b0;
            if (nv_start) pend_armed_q <= 1'b0;
            if (!cs_act) begin
                phase_q <= PH_ID;
            end else if (byte_stb) begin
                unique case (phase_q)
                    PH_ID: phase_q <= id_ok ? PH_INSN : PH_SKIP;
                    PH_INSN: begin
                        phase_q <= PH_SKIP;
                        op_q    <= ins_op;
                        ch_q    <= ch_i;
                        reg_q   <= reg_i;
                        if (ch_ok) begin
                            case (ins_op)
                                OP_STATUS: begin
                                    tx_load <= 1'b1;
                                    tx_byte <= {7'd0, nv_busy};
                                    phase_q <= PH_DATA;
                                end
                                OP_RD_WCR: begin
                                    tx_load <= 1'b1;
                                    tx_byte <= {{PAD_W{1'b0}}, wcr_q[ch_i]};
                                    phase_q <= PH_DATA;
                                end
                                OP_RD_DR: if (reg_ok) begin
                                    tx_load <= 1'b1;
                                    tx_byte <= {{PAD_W{1'b0}}, dr_q[ch_i][reg_i]};
                                    phase_q <= PH_DATA;
                                end
                                OP_WR_WCR: if (!nv_busy) phase_q <= PH_DATA;
                                OP_WR_DR: if (!nv_busy && wp_n && reg_ok) phase_q <= PH_DATA;
                                OP_DR2WCR: if (!nv_busy && reg_ok) wcr_q[ch_i] <= dr_q[ch_i][reg_i];
                                OP_WCR2DR: if (!nv_busy && wp_n && reg_ok) begin
                                    pend_armed_q <= 1'b1;
                                    pend_ch_q    <= ch_i;
                                    pend_reg_q   <= reg_i;
                                    pend_val_q   <= wcr_q[ch_i];
                                end
                                default: ;
                            endcase
                        end
                    end
                    PH_DATA: begin
                        phase_q <= PH_SKIP;
                        if (op_q == OP_WR_WCR) begin
                            wcr_q[ch_q] <= rx_byte[WCR_W-1:0];
                        end else if (op_q == OP_WR_DR) begin
                            pend_armed_q <= 1'b1;
                            pend_ch_q    <= ch_q;
                            pend_reg_q   <= reg_q;
                            pend_val_q   <= rx_byte[WCR_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Retained bank: written only when a save completes, never by reset.
    always_ff @(posedge clk) begin
        if (nv_done) dr_q[pend_ch_q][pend_reg_q] <= pend_val_q;
    end

    // Present the wiper registers as one flat vector.
    for (genvar c = 0; c < N_CH; c++) begin : g_flat
        assign wcr_flat[c*WCR_W +: WCR_W] = wcr_q[c];
    end

endmodule

// File: rtl/digipot_wiper_dec.sv
// Binary-to-one-hot decode of each channel's wiper into its switch lines.
// Assumes the wiper value always lies in 0 .. 2**WCR_W-1.
module digipot_wiper_dec #(
    parameter int N_CH  = 2,
    parameter int WCR_W = 6
) (
    input  logic [N_CH*WCR_W-1:0]       wcr_flat,
    output logic [N_CH*(2**WCR_W)-1:0]  sel
);

    localparam int TAPS = 2 ** WCR_W;

    // One decoder per channel.
    for (genvar c = 0; c < N_CH; c++) begin : g_dec
        assign sel[c*TAPS +: TAPS] = {{(TAPS-1){1'b0}}, 1'b1} << wcr_flat[c*WCR_W +: WCR_W];
    end

endmodule

// File: rtl/digipot_spi_ctrl.sv
// Top level of the dual-channel digital potentiometer serial controller.
// Connects the SPI front end, protocol engine, save timer and decoders.
// Assumes clk is at least 16x the SCK rate; MISO pad uses spi_miso_oe.
module digipot_spi_ctrl #(
    parameter int N_CH      = 2,
    parameter int WCR_W     = 6,
    parameter int N_DR      = 4,
    parameter int NV_CYCLES = 2000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sck,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic                       spi_miso_oe,
    input  logic                       hold_n,
    input  logic                       wp_n,
    input  logic [1:0]                 addr_strap,
    output logic [N_CH*(2**WCR_W)-1:0] wiper_sel,
    output logic                       nv_busy
);

    logic                  cs_act;
    logic                  cs_rise;
    logic                  byte_stb;
    logic [7:0]            rx_byte;
    logic                  tx_load;
    logic [7:0]            tx_byte;
    logic                  nv_start;
    logic                  nv_done;
    logic [N_CH*WCR_W-1:0] wcr_flat;

    digipot_spi_front front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .hold_n   (hold_n),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .cs_act   (cs_act),
        .cs_rise  (cs_rise),
        .byte_stb (byte_stb),
        .rx_byte  (rx_byte),
        .so_bit   (spi_miso),
        .so_oe    (spi_miso_oe)
    );

    digipot_cmd #(.N_CH(N_CH), .WCR_W(WCR_W), .N_DR(N_DR)) cmd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .cs_rise    (cs_rise),
        .byte_stb   (byte_stb),
        .rx_byte    (rx_byte),
        .addr_strap (addr_strap),
        .wp_n       (wp_n),
        .nv_busy    (nv_busy),
        .nv_done    (nv_done),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .nv_start   (nv_start),
        .wcr_flat   (wcr_flat)
    );

    digipot_nv_timer #(.NV_CYCLES(NV_CYCLES)) nv_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (nv_busy),
        .done  (nv_done)
    );

    digipot_wiper_dec #(.N_CH(N_CH), .WCR_W(WCR_W)) dec_i (
        .wcr_flat (wcr_flat),
        .sel      (wiper_sel)
    );

endmodule

// File: rtl/digipot_spi_ctrl_chk.sv
// Property checker for digipot_spi_ctrl, attached by bind below.
// Watches only top-level ports; the save length is tracked with a counter.
module digipot_spi_ctrl_chk #(
    parameter int N_CH      = 2,
    parameter int WCR_W     = 6,
    parameter int NV_CYCLES = 2000
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       spi_cs_n,
    input logic                       spi_miso_oe,
    input logic [N_CH*(2**WCR_W)-1:0] wiper_sel,
    input logic                       nv_busy
);

    localparam int TAPS = 2 ** WCR_W;

    int busy_len_q;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_len_q <= 0;
        else if (nv_busy) busy_len_q <= busy_len_q + 1;
        else              busy_len_q <= 0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_onehot
        AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(wiper_sel[c*TAPS +: TAPS]) == 1); // R2
    end

    AST_WIPER_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
        && $past(spi_cs_n, 4) && $past(rst_n) |-> $stable(wiper_sel)); // R1

    AST_MISO_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
        && $past(spi_cs_n, 4) |-> !spi_miso_oe); // R12

    AST_SAVE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> spi_cs_n); // R6

    AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |-> busy_len_q < NV_CYCLES); // R7

    AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_busy) |-> busy_len_q == NV_CYCLES); // R7

endmodule

bind digipot_spi_ctrl digipot_spi_ctrl_chk #(
    .N_CH(N_CH), .WCR_W(WCR_W), .NV_CYCLES(NV_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .wiper_sel   (wiper_sel),
    .nv_busy     (nv_busy)
);

// File: tb/digipot_spi_ctrl_tb_top.sv
// Directed bench for digipot_spi_ctrl: one task per scenario.
module digipot_spi_ctrl_tb_top;

    localparam int NV   = 2000;
    localparam int HALF = 8;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] ID_OK = {4'b0101, 2'b00, STRAP};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         cs_n = 1'b1;
    logic         mosi = 1'b0;
    logic         miso;
    logic         miso_oe;
    logic         hold_n = 1'b1;
    logic         wp_n = 1'b1;
    logic [127:0] sel;
    logic         busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    digipot_spi_ctrl #(.NV_CYCLES(NV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .hold_n      (hold_n),
        .wp_n        (wp_n),
        .addr_strap  (STRAP),
        .wiper_sel   (sel),
        .nv_busy     (busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Position of the single set line of a channel, -1 if not one-hot.
    function automatic int wiper_of(input int ch);
        int n = 0;
        int pos = -1;
        for (int k = 0; k < 64; k++) begin
            if (sel[ch*64 + k]) begin
                n++;
                pos = k;
            end
        end
        return (n == 1) ? pos : -1;
    endfunction

    task automatic spi_bit(input logic b, output logic r);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
    endtask

    task automatic sel_on;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_off;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    // Full three-byte transaction, returns the third byte seen on MISO.
    task automatic xact(input logic [7:0] id, input logic [7:0] ins,
                        input logic [7:0] dat, output logic [7:0] rd);
        logic [7:0] tmp;
        sel_on();
        spi_byte(id, tmp);
        spi_byte(ins, tmp);
        spi_byte(dat, rd);
        sel_off();
    endtask

    task automatic xact2(input logic [7:0] ins);
        logic [7:0] tmp;
        sel_on();
        spi_byte(ID_OK, tmp);
        spi_byte(ins, tmp);
        sel_off();
    endtask

    task automatic rd_cmd(input logic [7:0] ins, output logic [7:0] rd);
        xact(ID_OK, ins, 8'h00, rd);
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 3 * NV && busy; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 reset ch0 wiper", wiper_of(0), 0);
        chk("R2 reset ch1 one-hot", wiper_of(1), 0);
        chk("R7 reset busy", busy, 0);
        chk("R12 reset miso_oe", miso_oe, 0);
    endtask

    task automatic t_write_wiper;
        logic [7:0] rd;
        xact(ID_OK, 8'hA0, 8'd45, rd);
        xact(ID_OK, 8'hA1, 8'd7, rd);
        chk("R1 ch0 wiper", wiper_of(0), 45);
        chk("R2 ch1 wiper line", wiper_of(1), 7);
        rd_cmd(8'h90, rd);
        chk("R4 read ch0 wiper", rd, 45);
        rd_cmd(8'h91, rd);
        chk("R4 read ch1 wiper", rd, 7);
    endtask

    task automatic t_ident;
        logic [7:0] rd;
        xact(8'h62, 8'hA0, 8'd12, rd);
        chk("R5 bad type ignored", wiper_of(0), 45);
        xact(8'h51, 8'hA0, 8'd12, rd);
        chk("R5 bad address ignored", wiper_of(0), 45);
        xact(8'h5E, 8'hA0, 8'd12, rd);
        chk("R5 bits 3:2 don't care", wiper_of(0), 12);
    endtask

    task automatic t_bad_channel;
        logic [7:0] rd;
        xact(ID_OK, 8'hA2, 8'd3, rd);
        chk("R13 channel 2 ch0 kept", wiper_of(0), 12);
        chk("R13 channel 2 ch1 kept", wiper_of(1), 7);
    endtask

    task automatic t_save;
        logic [7:0] rd;
        logic [7:0] tmp;
        logic       b;
        sel_on();
        spi_byte(ID_OK, tmp);
        spi_byte(8'hC8, tmp);
        for (int i = 0; i < 4; i++) spi_bit(1'b1, b);
        sel_off();
        chk("R6 short write no save", busy, 0);
        xact(ID_OK, 8'hC8, 8'd50, rd);
        chk("R7 busy after commit", busy, 1);
        rd_cmd(8'h50, rd);
        chk("R7 status busy", rd, 1);
        rd_cmd(8'hB8, rd);
        chk("R6 DR unchanged mid-save", rd, 0);
        xact(ID_OK, 8'hA1, 8'd11, rd);
        chk("R8 wiper write rejected", wiper_of(1), 7);
        xact2(8'hD8);
        chk("R8 transfer rejected", wiper_of(0), 12);
        wait_idle();
        chk("R7 busy ends", busy, 0);
        rd_cmd(8'h50, rd);
        chk("R7 status idle", rd, 0);
        rd_cmd(8'hB8, rd);
        chk("R6 DR saved", rd, 50);
    endtask

    task automatic t_transfers;
        logic [7:0] rd;
        xact2(8'hD8);
        chk("R3 DR to wiper", wiper_of(0), 50);
        xact(ID_OK, 8'hA1, 8'd33, rd);
        xact2(8'hE1);
        chk("R6 wiper-to-DR busy", busy, 1);
        wait_idle();
        rd_cmd(8'hB1, rd);
        chk("R6 wiper-to-DR saved", rd, 33);
    endtask

    task automatic t_protect;
        logic [7:0] rd;
        wp_n = 1'b0;
        xact(ID_OK, 8'hC4, 8'd9, rd);
        chk("R9 protected no save", busy, 0);
        xact2(8'hE0);
        chk("R9 protected transfer no save", busy, 0);
        wp_n = 1'b1;
        rd_cmd(8'hB4, rd);
        chk("R9 DR1 unchanged", rd, 0);
        rd_cmd(8'hB0, rd);
        chk("R9 DR0 unchanged", rd, 0);
    endtask

    task automatic t_hold;
        logic [7:0] tmp;
        logic [7:0] v = 8'd21;
        logic       b;
        sel_on();
        spi_byte(ID_OK, tmp);
        spi_byte(8'hA1, tmp);
        chk("R12 miso_oe while selected", miso_oe, 1);
        for (int i = 7; i >= 5; i--) spi_bit(v[i], b);
        hold_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk("R11 miso_oe low in hold", miso_oe, 0);
        spi_bit(1'b1, b);
        spi_bit(1'b0, b);
        hold_n = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = 4; i >= 0; i--) spi_bit(v[i], b);
        sel_off();
        chk("R11 hold keeps transfer", wiper_of(1), 21);
        chk("R12 miso_oe after deselect", miso_oe, 0);
    endtask

    task automatic t_rereset;
        logic [7:0] rd;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 ch0 wiper from DR0", wiper_of(0), 0);
        chk("R10 ch1 wiper from DR0", wiper_of(1), 33);
        rd_cmd(8'hB8, rd);
        chk("R10 DR retained", rd, 50);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_wiper();
        t_ident();
        t_bad_channel();
        t_save();
        t_transfers();
        t_protect();
        t_hold();
        t_rereset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule